// File: doc/BRIEF.md
# External Memory Bus Controller

This block connects an 8-bit processor core to parallel memory or peripherals outside the chip. Each access first presents the full address: the low byte goes out on a shared address/data bus and the high byte on a separate set of pins, while an address latch enable pulse lets an external latch capture the low byte. In the following cycles the shared bus carries the data, under an active-low write strobe or an active-low read strobe.

Two configuration registers control the block. While the enable bit is set, the block takes ownership of the shared pins through an override signal to the port logic. The 64 KiB address space can be split at a programmable eighth into a lower sector and an upper sector. Each sector has its own 2-bit wait code, so slow and fast devices can share the bus. A legacy mode replaces both sector codes with a single wait bit.

The core issues requests on a valid/ready channel. A request is taken on a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low while a bus cycle is in flight or while the block is disabled, and this is the only back-pressure: the core holds its request until it is taken. Completion is reported by a single-cycle `rsp_valid` pulse that cannot be stalled. For reads, `rsp_rdata` holds the captured data during that pulse.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset, both configuration registers read zero, `req_ready` is low and `pin_override` is low.
- R2: The enable bit is bit 0 of the control register (`cfg_addr`=0). `pin_override` is high whenever this bit is set or a bus cycle is in flight. Clearing the bit during an access lets that access finish.
- R3: Bit 7 of the sector register (`cfg_addr`=1) always reads zero, whatever value is written to it.
- R4: With the sector limit (sector register bits 6:4) at zero, every address uses the upper wait code (sector register bits 3:2).
- R5: With the sector limit L in the range 1 to 7, an address whose top three bits are at least L uses the upper wait code. Any other address uses the lower wait code (sector register bits 1:0).
- R6: A wait code of 0, 1 or 2 holds the strobe low for 1, 2 or 3 cycles.
- R7: A wait code of 3 holds the strobe low for 3 cycles. It then adds one hold cycle with both strobes high and the address pins unchanged.
- R8: When legacy mode (control bit 1) is set, the sector codes are ignored. The strobe then lasts 1 cycle, plus 1 more when the legacy wait bit (control bit 2) is set.
- R9: An accepted request is followed by exactly one address cycle. In that cycle `bus_ale` is high, the low address byte is driven on `bus_ad_out`, and the high byte is on `bus_a_hi`. `bus_a_hi` keeps that value until the access ends.
- R10: During a write strobe, `bus_ad_out` drives the write data with `bus_ad_oe` high. During a read strobe, `bus_ad_oe` is low, and `bus_ad_in` is captured on the last strobe cycle and returned on `rsp_rdata`.
- R11: `req_ready` is high only when the block is enabled and idle. `rsp_valid` pulses for one cycle, in the cycle after the last strobe or hold cycle. A new request can be taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 = control, 1 = sector |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read data |
| bus_ad_out | output | 8 | Multiplexed low address / data out |
| bus_ad_oe | output | 1 | Output enable for the shared bus |
| bus_ad_in | input | 8 | Shared bus input |
| bus_a_hi | output | 8 | High address byte |
| bus_ale | output | 1 | Address latch enable |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| pin_override | output | 1 | Takes the shared pins from the port logic |

## Verification
The bench checks the sector boundary from both sides: at 0x7FFF and 0x8000 with limit 4, and at 0xDFFF and 0xE000 with limit 7. A comparator off by one would give the wrong wait count on exactly one of these addresses. Wait code 3 is checked for its extra hold cycle, which a design that only stretched the strobe would omit. Legacy mode is checked to ignore sector codes that would otherwise stretch the strobe. The enable bit is cleared in the middle of a strobe, where a design that dropped the override at once would let go of the pins mid-access. Requests made while the block is disabled must never be taken. A read must return the bus value captured on the final strobe cycle.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  localparam int LIM_W  = 3;
  localparam int CODE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2,
    ST_HOLD = 2'd3
  } xmb_state_e;

  typedef struct packed {
    logic              en;
    logic              legacy;
    logic              legacy_wait;
    logic [CODE_W-1:0] wait_lo;
    logic [CODE_W-1:0] wait_hi;
    logic [LIM_W-1:0]  limit;
  } xmb_cfg_t;
endpackage

// File: rtl/xmb_regs.sv
module xmb_regs
  import xmb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output xmb_cfg_t          cfg
);
  localparam int LIM_LSB = 2 * CODE_W;

  logic unused_wbits;
  assign unused_wbits = ^cfg_wdata[DATA_W-1:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_wr) begin
      if (!cfg_addr) begin
        cfg.en          <= cfg_wdata[0];
        cfg.legacy      <= cfg_wdata[1];
        cfg.legacy_wait <= cfg_wdata[2];
      end else begin
        cfg.wait_lo <= cfg_wdata[CODE_W-1:0];
        cfg.wait_hi <= cfg_wdata[2*CODE_W-1:CODE_W];
        cfg.limit   <= cfg_wdata[LIM_LSB+LIM_W-1:LIM_LSB];
      end
    end
  end

  // the top bit of the sector register is reserved and never stored
  always_comb begin
    cfg_rdata = '0;
    if (!cfg_addr) begin
      cfg_rdata[2:0] = {cfg.legacy_wait, cfg.legacy, cfg.en};
    end else begin
      cfg_rdata[CODE_W-1:0]               = cfg.wait_lo;
      cfg_rdata[2*CODE_W-1:CODE_W]        = cfg.wait_hi;
      cfg_rdata[LIM_LSB+LIM_W-1:LIM_LSB]  = cfg.limit;
    end
  end
endmodule

// File: rtl/xmb_sector_decode.sv
module xmb_sector_decode
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  xmb_cfg_t          cfg,
  output logic [1:0]        extra_strobe,
  output logic              hold_en
);
  logic [LIM_W-1:0]  sector_idx;
  logic              upper;
  logic [CODE_W-1:0] code;

  assign sector_idx = addr[ADDR_W-1 -: LIM_W];
  assign upper      = (cfg.limit == '0) || (sector_idx >= cfg.limit);

  always_comb begin
    if (cfg.legacy)
      code = {1'b0, cfg.legacy_wait};
    else if (upper)
      code = cfg.wait_hi;
    else
      code = cfg.wait_lo;
  end

  assign hold_en      = (code == 2'd3);
  assign extra_strobe = hold_en ? 2'd2 : code;
endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [1:0]               extra_strobe,
  input  logic                     hold_en,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_in,
  output logic [ADDR_W-DATA_W-1:0] bus_a_hi,
  output logic                     bus_ale,
  output logic                     bus_wr_n,
  output logic                     bus_rd_n,
  output logic                     busy
);
  localparam int HI_W = ADDR_W - DATA_W;

  xmb_state_e        state;
  logic [1:0]        cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic              hold_q;

  assign req_ready = (state == ST_IDLE) && enable;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      hold_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            hold_q  <= hold_en;
            cnt     <= extra_strobe;
            state   <= ST_ADDR;
          end
        end
        ST_ADDR: state <= ST_STRB;
        ST_STRB: begin
          if (cnt != '0) begin
            cnt <= cnt - 2'd1;
          end else begin
            if (!write_q) rsp_rdata <= bus_ad_in;
            if (hold_q) begin
              state <= ST_HOLD;
            end else begin
              state     <= ST_IDLE;
              rsp_valid <= 1'b1;
            end
          end
        end
        default: begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    bus_ale    = (state == ST_ADDR);
    bus_wr_n   = !((state == ST_STRB) && write_q);
    bus_rd_n   = !((state == ST_STRB) && !write_q);
    bus_a_hi   = busy ? addr_q[ADDR_W-1 -: HI_W] : '0;
    bus_ad_oe  = 1'b0;
    bus_ad_out = '0;
    if (state == ST_ADDR) begin
      bus_ad_oe  = 1'b1;
      bus_ad_out = addr_q[DATA_W-1:0];
    end else if (busy && write_q) begin
      bus_ad_oe  = 1'b1;
      bus_ad_out = wdata_q;
    end
  end
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic                     cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output logic [DATA_W-1:0]        cfg_rdata,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_in,
  output logic [ADDR_W-DATA_W-1:0] bus_a_hi,
  output logic                     bus_ale,
  output logic                     bus_wr_n,
  output logic                     bus_rd_n,
  output logic                     pin_override
);
  xmb_cfg_t   cfg;
  logic [1:0] extra_strobe;
  logic       hold_en;
  logic       busy;

  xmb_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg(cfg)
  );

  xmb_sector_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .cfg(cfg), .extra_strobe(extra_strobe), .hold_en(hold_en)
  );

  xmb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(cfg.en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .extra_strobe(extra_strobe), .hold_en(hold_en),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_a_hi(bus_a_hi), .bus_ale(bus_ale), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .busy(busy)
  );

  assign pin_override = cfg.en || busy;
endmodule

// File: rtl/xmb_checker.sv
module xmb_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bus_ad_oe,
  input logic              bus_ale,
  input logic              bus_wr_n,
  input logic              bus_rd_n,
  input logic              pin_override
);
  a_r9_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);
  a_r9_accept_then_ale: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> bus_ale);
  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n));
  a_r10_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe);
  a_r2_override_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ale || !bus_wr_n || !bus_rd_n) |-> pin_override);
  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r11_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ale || !bus_wr_n || !bus_rd_n) |-> !req_ready);
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr |-> !cfg_rdata[DATA_W-1]);
endmodule

bind xmem_bus_ctrl xmb_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/xmem_bus_ctrl_bench.sv
module xmem_bus_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cfg_wr = 0, cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic       req_valid = 0, req_ready, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata, bus_ad_out, bus_ad_in = 0, bus_a_hi;
  logic       bus_ad_oe, bus_ale, bus_wr_n, bus_rd_n, pin_override;

  xmem_bus_ctrl u_xmem_bus_ctrl (.*);

  typedef struct {
    bit busy, ale, wrn, rdn, oe, rsp, rd;
    bit [7:0] ad, hi, rdv;
  } cyc_t;

  int checks = 0, failures = 0, cycles = 0;
  string tag = "R1";
  cyc_t q[$];
  cyc_t cur;
  bit m_en, m_leg, m_lw, m_acc;
  bit [1:0] m_wlo, m_whi;
  bit [2:0] m_lim;

  function automatic cyc_t idle_rec();
    cyc_t r;
    r = '{default: 0};
    r.wrn = 1; r.rdn = 1;
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model: on acceptance the whole expected pin history is queued
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); cur = idle_rec();
      m_en = 0; m_leg = 0; m_lw = 0; m_wlo = 0; m_whi = 0; m_lim = 0; m_acc = 0;
    end else begin
      int code, ext;
      cyc_t r;
      m_acc = req_valid && m_en && !cur.busy;
      if (m_acc) begin
        if (m_leg) code = m_lw;
        else if (m_lim == 0 || req_addr[15:13] >= m_lim) code = m_whi;
        else code = m_wlo;
        ext = (code == 3) ? 2 : code;
        r = idle_rec(); r.busy = 1; r.ale = 1; r.oe = 1;
        r.ad = req_addr[7:0]; r.hi = req_addr[15:8];
        q.push_back(r);
        for (int i = 0; i <= ext; i++) begin
          r = idle_rec(); r.busy = 1; r.hi = req_addr[15:8];
          r.wrn = !req_write; r.rdn = req_write; r.oe = req_write; r.ad = req_wdata;
          q.push_back(r);
        end
        if (code == 3) begin
          r = idle_rec(); r.busy = 1; r.hi = req_addr[15:8];
          r.oe = req_write; r.ad = req_wdata;
          q.push_back(r);
        end
        r = idle_rec(); r.rsp = 1; r.rd = !req_write; r.rdv = bus_ad_in;
        q.push_back(r);
      end
      if (cfg_wr) begin
        if (!cfg_addr) begin m_en = cfg_wdata[0]; m_leg = cfg_wdata[1]; m_lw = cfg_wdata[2]; end
        else begin m_wlo = cfg_wdata[1:0]; m_whi = cfg_wdata[3:2]; m_lim = cfg_wdata[6:4]; end
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = idle_rec();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(bus_ale == cur.ale, "R9", "ale", bus_ale, cur.ale);
      chk({bus_wr_n, bus_rd_n} == {cur.wrn, cur.rdn}, tag, "strobes",
          {bus_wr_n, bus_rd_n}, {cur.wrn, cur.rdn});
      chk(bus_ad_oe == cur.oe, "R10", "ad_oe", bus_ad_oe, cur.oe);
      if (cur.oe) chk(bus_ad_out == cur.ad, "R10", "ad_out", bus_ad_out, cur.ad);
      if (cur.busy) chk(bus_a_hi == cur.hi, "R9", "a_hi", bus_a_hi, cur.hi);
      chk(req_ready == (m_en && !cur.busy), "R11", "req_ready", req_ready, m_en && !cur.busy);
      chk(pin_override == (m_en || cur.busy), "R2", "override", pin_override, m_en || cur.busy);
      chk(rsp_valid == cur.rsp, "R11", "rsp_valid", rsp_valid, cur.rsp);
      if (cur.rsp && cur.rd) chk(rsp_rdata == cur.rdv, "R10", "rsp_rdata", rsp_rdata, cur.rdv);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(bit a, bit [7:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 0;
  endtask

  task automatic cfg_read(bit a, bit [7:0] exp, string req);
    cfg_addr = a;
    @(negedge clk);
    chk(cfg_rdata == exp, req, "cfg_rdata", cfg_rdata, exp);
    step();
  endtask

  task automatic access(bit w, bit [15:0] a, bit [7:0] d, bit [7:0] pat);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; bus_ad_in = pat;
    for (int i = 0; i < 50; i++) begin step(); if (m_acc) break; end
    req_valid = 0;
    for (int i = 0; i < 50; i++) begin if (cur.rsp) break; step(); end
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    tag = "R1";
    cfg_read(0, 8'h00, "R1");
    cfg_read(1, 8'h00, "R1");
    chk(req_ready == 0 && pin_override == 0, "R1", "ready/override", {req_ready, pin_override}, 0);

    tag = "R3";
    cfg_write(1, 8'hFF);
    cfg_read(1, 8'h7F, "R3");
    cfg_write(1, 8'h00);
    cfg_read(1, 8'h00, "R3");

    tag = "R2";
    req_valid = 1; req_addr = 16'h1234;
    repeat (5) step();
    chk(m_acc == 0 && rsp_valid == 0, "R2", "accept while disabled", m_acc, 0);
    req_valid = 0;
    cfg_write(0, 8'h01);
    cfg_read(0, 8'h01, "R2");

    tag = "R4";                         // limit 0, upper code 2
    cfg_write(1, 8'h08);
    access(1, 16'h0100, 8'hA5, 8'h00);
    access(0, 16'hF000, 8'h00, 8'h3C);

    tag = "R5";                         // limit 4, lower code 1, upper code 0
    cfg_write(1, 8'h41);
    access(0, 16'h7FFF, 8'h00, 8'h81);
    access(1, 16'h8000, 8'h5A, 8'h00);
    cfg_write(1, 8'h72);                // limit 7, lower code 2, upper code 0
    access(1, 16'hDFFF, 8'h11, 8'h00);
    access(0, 16'hE000, 8'h00, 8'h22);

    tag = "R6";
    cfg_write(1, 8'h00);
    access(0, 16'h4321, 8'h00, 8'h99);
    cfg_write(1, 8'h04);
    access(1, 16'h4321, 8'h77, 8'h00);

    tag = "R7";
    cfg_write(1, 8'h0C);
    access(1, 16'hBEEF, 8'hC3, 8'h00);
    access(0, 16'h0001, 8'h00, 8'hE7);

    tag = "R8";
    cfg_write(1, 8'h2F);                // sector codes 3 everywhere, must be ignored
    cfg_write(0, 8'h03);
    access(0, 16'h6000, 8'h00, 8'h4D);
    cfg_write(0, 8'h07);
    access(1, 16'h6001, 8'hD2, 8'h00);

    tag = "R11";                        // back-to-back with the request held
    cfg_write(0, 8'h01);
    cfg_write(1, 8'h00);
    req_valid = 1; req_write = 1; req_addr = 16'h2222; req_wdata = 8'h66;
    for (int i = 0; i < 20; i++) begin step(); if (m_acc) break; end
    for (int i = 0; i < 20; i++) begin step(); if (m_acc) break; end
    chk(m_acc == 1, "R11", "accept in rsp cycle", m_acc, 1);
    req_valid = 0;
    for (int i = 0; i < 20; i++) begin if (cur.rsp) break; step(); end

    tag = "R2";                         // disable mid-access
    cfg_write(1, 8'h08);
    req_valid = 1; req_write = 0; req_addr = 16'h3333; bus_ad_in = 8'h5E;
    for (int i = 0; i < 20; i++) begin step(); if (m_acc) break; end
    req_valid = 0;
    step();
    cfg_write(0, 8'h00);
    chk(pin_override == 1, "R2", "override held mid-access", pin_override, 1);
    for (int i = 0; i < 20; i++) begin if (cur.rsp) break; step(); end
    step();
    chk(pin_override == 0, "R2", "override released", pin_override, 0);
    repeat (3) step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule